// File: doc/BRIEF.md
# Width-Adaptive Memory Access Sequencer

This block sits between an execution core and an external memory bus with a 20-bit byte address, a two-bit byte-enable pair and a 16-bit data path. The core asks for a byte or a 16-bit word, to read or to write. The block turns each request into one or two bus cycles, steers each byte onto the correct data lane, rebuilds read data in the core's byte order and returns one completion pulse. A mode input selects a 16-bit or an 8-bit external bus. Alignment and bus width change only how many bus cycles a request costs. They never change the value read or written.

The block also holds the instruction fetch pointer. A program transfer loads the pointer with a new target. Each fetch request then reads at the pointer, sized to the bus: on the 16-bit bus a fetch is an even-address word, except that a fetch from an odd pointer (the first fetch after a transfer to an odd target) returns a single byte and realigns the pointer. On the 8-bit bus every fetch is one byte. The pointer advances by the number of bytes fetched, modulo 2^20.

Top module: `mem_width_seq`

## Requirements
- R1: With the 16-bit bus selected, a word at an even address takes exactly one bus cycle at that address with `bus_be` = 2'b11 (bit 0 is the low lane, data bits 7:0; bit 1 is the high lane, data bits 15:8), and it moves the whole word.
- R2: With the 16-bit bus selected, a word at an odd address A takes two consecutive bus cycles: first A with `bus_be` = 2'b10, carrying write data bits 7:0 on lane bits 15:8; then A+1 with `bus_be` = 2'b01, carrying write data bits 15:8 on lane bits 7:0.
- R3: A byte request takes one bus cycle at its own address. On the 16-bit bus an even address uses `bus_be` = 2'b01 with the byte on bits 7:0, and an odd address uses `bus_be` = 2'b10 with the byte on bits 15:8. A byte read returns the byte in `rdata[7:0]`, with `rdata[15:8]` = 0 and `rd_bytes` = 1.
- R4: With the 8-bit bus selected (`bus8_mode` = 1), every bus cycle uses `bus_be` = 2'b01 and data bits 7:0. A word always takes two cycles, at A and then A+1, whether A is even or odd.
- R5: A word read returns {byte at A+1, byte at A} in `rdata`, with `rd_bytes` = 2, for any alignment and either bus width.
- R6: A bus cycle stays on the bus, with address, enables, write flag and write data unchanged, until `bus_rdy` is sampled high.
- R7: `done` is a one-cycle pulse, asserted in the cycle after the handshake of the last bus cycle of the request. It is never asserted after an earlier cycle.
- R8: Addresses wrap modulo 2^20, so a word at FFFFFh takes its high byte from 00000h, and the fetch pointer wraps in the same way.
- R9: On the 16-bit bus, a fetch from an even pointer is one word cycle (`bus_be` = 2'b11) and advances the pointer by 2. A fetch from an odd pointer is one byte cycle on the high lane (`bus_be` = 2'b10), returned in `rdata[7:0]` with `rd_bytes` = 1, and it advances the pointer by 1.
- R10: On the 8-bit bus, each fetch is a single byte cycle at the pointer and advances the pointer by 1.
- R11: A pulse on `xfer_valid` loads `xfer_target` into the fetch pointer (`fetch_addr`) at the next clock. A fetch uses the pointer and ignores `req_addr`, `req_write` and `req_word`.
- R12: `req_valid` is sampled only while `busy` is low. A request presented while busy starts no bus cycle and writes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus8_mode | input | 1 | 1 selects the 8-bit external bus, 0 selects the 16-bit bus |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_fetch | input | 1 | Request is an instruction fetch at the fetch pointer |
| req_write | input | 1 | Operand write (0 = read) |
| req_word | input | 1 | Operand is a 16-bit word (0 = byte) |
| req_addr | input | 20 | Operand byte address |
| req_wdata | input | 16 | Operand write data, byte at the address in bits 7:0 |
| xfer_valid | input | 1 | Program transfer, loads the fetch pointer |
| xfer_target | input | 20 | Program transfer target address |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read data |
| rd_bytes | output | 2 | Number of valid bytes in rdata (1 or 2) |
| fetch_addr | output | 20 | Current instruction fetch pointer |
| bus_cyc | output | 1 | Bus cycle active |
| bus_wr | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus byte address |
| bus_be | output | 2 | Lane enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_rdy | input | 1 | Bus cycle completes at this edge |

## Verification
The bench targets the odd-word split, where a design that swaps lanes or byte order writes the two bytes into each other's places and reads back a byte-swapped word. It also targets the wrap at the top of memory, where a carry past bit 19 would fetch the high byte from the wrong place. Wait states are stretched so that a design that pulses done after the first half of a split, or moves the address while waiting, shows a wrong cycle count or a wrong log. Fetch sizing is checked after transfers to odd and even targets on both bus widths, because a design that keeps fetching bytes, or never drops to one, leaves the pointer on the wrong address. A request pushed in while busy must leave no bus cycle and no memory write behind.

// File: rtl/mws_pkg.sv
package mws_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic fetch;
    logic write;
    logic word;
    logic bus8;
  } req_kind_t;
endpackage

// File: rtl/mws_planner.sv
module mws_planner (
  input  logic       bus8,
  input  logic       fetch,
  input  logic       word,
  input  logic       addr_lsb,
  output logic       full,
  output logic       split,
  output logic [1:0] nbytes
);
  logic eff_word;

  always_comb begin
    // a fetch is a word only when the 16-bit bus can deliver it in one aligned cycle
    eff_word = fetch ? (!bus8 && !addr_lsb) : word;
    split    = eff_word && (bus8 || addr_lsb);
    full     = eff_word && !split;
    nbytes   = eff_word ? 2'd2 : 2'd1;
  end
endmodule

// File: rtl/mws_lane_steer.sv
module mws_lane_steer
  import mws_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              bus8,
  input  logic              full,
  input  logic              phase,
  input  logic [AW-1:0]     base,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [AW-1:0]     cyc_addr,
  output logic [1:0]        be,
  output logic [DATA_W-1:0] wdata_out,
  output logic [BYTE_W-1:0] rd_byte
);
  logic              hi_lane;
  logic [BYTE_W-1:0] wr_byte;

  always_comb begin
    cyc_addr = base + AW'(phase);
    hi_lane  = !bus8 && cyc_addr[0];
    wr_byte  = phase ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];
    if (full) begin
      be        = 2'b11;
      wdata_out = wdata;
    end else if (hi_lane) begin
      be        = 2'b10;
      wdata_out = {wr_byte, {BYTE_W{1'b0}}};
    end else begin
      be        = 2'b01;
      wdata_out = {{BYTE_W{1'b0}}, wr_byte};
    end
    rd_byte = hi_lane ? rdata_in[DATA_W-1:BYTE_W] : rdata_in[BYTE_W-1:0];
  end
endmodule

// File: rtl/mws_assembler.sv
module mws_assembler
  import mws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_l,
  input  logic              cap_en,
  input  logic              full,
  input  logic              phase,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    data_n = data_q;
    if (cap_en) begin
      if (full) begin
        data_n = rdata_in;
      end else if (!phase) begin
        data_n = {{BYTE_W{1'b0}}, rd_byte};
      end else begin
        data_n[DATA_W-1:BYTE_W] = rd_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) data_q <= '0;
    else        data_q <= data_n;
  end

  assign data = data_q;

  // R3: the first byte of a narrow access clears the upper byte
  a_r3_upper_cleared: assert property (@(posedge clk) disable iff (!rst_l)
    (cap_en && !full && !phase) |=> (data[DATA_W-1:BYTE_W] == '0));

  // R5: the second byte of a split lands in the upper byte and keeps the lower byte
  a_r5_second_byte_high: assert property (@(posedge clk) disable iff (!rst_l)
    (cap_en && !full && phase) |=>
      (data == {$past(rd_byte), $past(data[BYTE_W-1:0])}));
endmodule

// File: rtl/mws_fetch_ptr.sv
module mws_fetch_ptr #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_l,
  input  logic          load,
  input  logic [AW-1:0] target,
  input  logic          adv,
  input  logic [1:0]    adv_bytes,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (load)     ptr_n = target;
    else if (adv) ptr_n = ptr_q + AW'(adv_bytes);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;

  a_r11_load_target: assert property (@(posedge clk) disable iff (!rst_l)
    load |=> (ptr == $past(target)));

  // R9: advance by exactly the bytes fetched, modulo the address space
  a_r9_advance: assert property (@(posedge clk) disable iff (!rst_l)
    (adv && !load) |=> (ptr == $past(ptr) + AW'($past(adv_bytes))));
endmodule

// File: rtl/mem_width_seq.sv
module mem_width_seq
  import mws_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus8_mode,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              xfer_valid,
  input  logic [AW-1:0]     xfer_target,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rd_bytes,
  output logic [AW-1:0]     fetch_addr,
  output logic              bus_cyc,
  output logic              bus_wr,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_l    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_l    <= rst_meta;
    end
  end

  seq_state_e        st_q, st_n;
  logic              phase_q, phase_n;
  req_kind_t         kind_q, kind_n;
  logic [AW-1:0]     base_q, base_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              done_q, done_n;
  logic [1:0]        bytes_q, bytes_n;

  logic              full, split, last, hs;
  logic [1:0]        nbytes;
  logic [AW-1:0]     cyc_addr, ptr;
  logic [1:0]        be;
  logic [DATA_W-1:0] steer_wd;
  logic [BYTE_W-1:0] rd_byte;

  mws_planner u_plan (
    .bus8     (kind_q.bus8),
    .fetch    (kind_q.fetch),
    .word     (kind_q.word),
    .addr_lsb (base_q[0]),
    .full     (full),
    .split    (split),
    .nbytes   (nbytes)
  );

  mws_lane_steer #(.AW(AW)) u_steer (
    .bus8      (kind_q.bus8),
    .full      (full),
    .phase     (phase_q),
    .base      (base_q),
    .wdata     (wd_q),
    .rdata_in  (bus_rdata),
    .cyc_addr  (cyc_addr),
    .be        (be),
    .wdata_out (steer_wd),
    .rd_byte   (rd_byte)
  );

  assign hs   = (st_q == ST_BUS) && bus_rdy;
  assign last = !split || phase_q;

  mws_assembler u_asm (
    .clk      (clk),
    .rst_l    (rst_l),
    .cap_en   (hs && !kind_q.write),
    .full     (full),
    .phase    (phase_q),
    .rdata_in (bus_rdata),
    .rd_byte  (rd_byte),
    .data     (rdata)
  );

  mws_fetch_ptr #(.AW(AW)) u_fptr (
    .clk       (clk),
    .rst_l     (rst_l),
    .load      (xfer_valid),
    .target    (xfer_target),
    .adv       (hs && last && kind_q.fetch),
    .adv_bytes (nbytes),
    .ptr       (ptr)
  );

  // next-state process
  always_comb begin
    st_n    = st_q;
    phase_n = phase_q;
    kind_n  = kind_q;
    base_n  = base_q;
    wd_n    = wd_q;
    bytes_n = bytes_q;
    done_n  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_n         = ST_BUS;
          phase_n      = 1'b0;
          kind_n.fetch = req_fetch;
          kind_n.write = req_write && !req_fetch;
          kind_n.word  = req_word;
          kind_n.bus8  = bus8_mode;
          base_n       = req_fetch ? ptr : req_addr;
          wd_n         = req_fetch ? '0 : req_wdata;
        end
      end
      ST_BUS: begin
        if (bus_rdy) begin
          if (last) begin
            st_n    = ST_IDLE;
            phase_n = 1'b0;
            done_n  = 1'b1;
            bytes_n = nbytes;
          end else begin
            phase_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      kind_q  <= '0;
      base_q  <= '0;
      wd_q    <= '0;
      done_q  <= 1'b0;
      bytes_q <= 2'd0;
    end else begin
      st_q    <= st_n;
      phase_q <= phase_n;
      kind_q  <= kind_n;
      base_q  <= base_n;
      wd_q    <= wd_n;
      done_q  <= done_n;
      bytes_q <= bytes_n;
    end
  end

  assign busy       = (st_q == ST_BUS);
  assign bus_cyc    = (st_q == ST_BUS);
  assign bus_wr     = bus_cyc && kind_q.write;
  assign bus_addr   = cyc_addr;
  assign bus_be     = bus_cyc ? be : 2'b00;
  assign bus_wdata  = bus_wr ? steer_wd : '0;
  assign done       = done_q;
  assign rd_bytes   = bytes_q;
  assign fetch_addr = ptr;

  a_r6_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_cyc && !bus_rdy) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be)
                               && $stable(bus_wdata) && $stable(bus_wr)));

  // R2 and R8: the second half of a split follows at the next address, wrapping
  a_r2_second_half_next_addr: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_cyc && bus_rdy && split && !phase_q) |=>
      (bus_cyc && (bus_addr == $past(bus_addr) + AW'(1))));

  a_r7_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_l)
    done |=> !done);

  a_r7_done_after_handshake: assert property (@(posedge clk) disable iff (!rst_l)
    done |-> $past(bus_cyc && bus_rdy));

  a_r4_narrow_bus_low_lane: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_cyc && kind_q.bus8) |-> (bus_be == 2'b01));

  a_r1_full_lanes_aligned: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_cyc && bus_be == 2'b11) |-> (!kind_q.bus8 && !bus_addr[0]));

  a_r3_lanes_nonempty: assert property (@(posedge clk) disable iff (!rst_l)
    bus_cyc |-> (bus_be != 2'b00));
endmodule

// File: tb/mem_width_seq_test.sv
module mem_width_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus8 = 1'b0;
  logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        xfer_valid = 1'b0;
  logic [19:0] xfer_target = '0;
  logic        busy, done, bus_cyc, bus_wr;
  logic [15:0] rdata, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_rdy = 1'b0;
  logic [1:0]  rd_bytes, bus_be;
  logic [19:0] fetch_addr, bus_addr;

  int nchk = 0, nerr = 0;
  int ws = 0, wcnt = 0, nlog = 0;
  logic [19:0] lg_a [8];
  logic [1:0]  lg_be [8];
  logic [15:0] lg_wd [8];
  logic        lg_wr [8];
  logic [7:0]  mem [int];
  logic [15:0] got_data;
  logic [1:0]  got_bytes;
  int          got_cyc;

  mem_width_seq uut (
    .clk(clk), .rst_n(rst_n), .bus8_mode(bus8), .req_valid(req_valid),
    .req_fetch(req_fetch), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .xfer_valid(xfer_valid),
    .xfer_target(xfer_target), .busy(busy), .done(done), .rdata(rdata),
    .rd_bytes(rd_bytes), .fetch_addr(fetch_addr), .bus_cyc(bus_cyc),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_mem(input logic [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return pat(a);
  endfunction

  // bus model: ready, logging and memory, all changed away from the active edge
  always @(negedge clk) begin
    if (bus8) bus_rdata = {8'hEE, rd_mem(bus_addr)};
    else      bus_rdata = {rd_mem({bus_addr[19:1], 1'b1}), rd_mem({bus_addr[19:1], 1'b0})};
    if (bus_cyc) begin
      if (wcnt < ws) begin
        bus_rdy = 1'b0;
        wcnt++;
      end else begin
        bus_rdy = 1'b1;
        wcnt = 0;
        if (nlog < 8) begin
          lg_a[nlog] = bus_addr; lg_be[nlog] = bus_be;
          lg_wd[nlog] = bus_wdata; lg_wr[nlog] = bus_wr;
        end
        nlog++;
        if (bus_wr) begin
          if (bus8) mem[int'(bus_addr)] = bus_wdata[7:0];
          else begin
            if (bus_be[0]) mem[int'({bus_addr[19:1], 1'b0})] = bus_wdata[7:0];
            if (bus_be[1]) mem[int'({bus_addr[19:1], 1'b1})] = bus_wdata[15:8];
          end
        end
      end
    end else begin
      bus_rdy = 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run(input logic f, input logic w, input logic wd, input logic [19:0] a,
                     input logic [15:0] d, input logic intrude);
    int cyc;
    @(negedge clk);
    nlog = 0;
    req_fetch = f; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      cyc++;
      if (intrude && cyc == 1) begin
        req_fetch = 1'b0; req_write = 1'b1; req_word = 1'b1;
        req_addr = 20'hA00; req_wdata = 16'h7777; req_valid = 1'b1;
      end
      if (intrude && cyc == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    chk("R7", "completion seen", 32'(cyc < 200), 32'd1);
    got_cyc = cyc; got_data = rdata; got_bytes = rd_bytes;
    @(negedge clk);
    chk("R7", "done is one cycle wide", 32'(done), 32'd0);
  endtask

  task automatic xfer(input logic [19:0] t);
    @(negedge clk);
    xfer_target = t; xfer_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0;
    chk("R11", "pointer loaded", 32'(fetch_addr), 32'(t));
  endtask

  task automatic t_reset;
    chk("reset", "busy", 32'(busy), 32'd0);
    chk("reset", "bus_cyc", 32'(bus_cyc), 32'd0);
    chk("reset", "done", 32'(done), 32'd0);
    chk("reset", "fetch_addr", 32'(fetch_addr), 32'd0);
  endtask

  task automatic t_r1_aligned_word;
    bus8 = 1'b0; ws = 0;
    run(0, 1, 1, 20'h00100, 16'hBEEF, 0);
    chk("R1", "cycles", 32'(nlog), 32'd1);
    chk("R1", "addr", 32'(lg_a[0]), 32'h100);
    chk("R1", "be", 32'(lg_be[0]), 32'h3);
    chk("R1", "wdata", 32'(lg_wd[0]), 32'hBEEF);
    run(0, 0, 1, 20'h00100, 16'h0, 0);
    chk("R1", "read cycles", 32'(nlog), 32'd1);
    chk("R5", "aligned read data", 32'(got_data), 32'hBEEF);
    chk("R5", "aligned read bytes", 32'(got_bytes), 32'd2);
  endtask

  task automatic t_r2_odd_word;
    bus8 = 1'b0; ws = 0;
    run(0, 1, 1, 20'h00203, 16'h1234, 0);
    chk("R2", "cycles", 32'(nlog), 32'd2);
    chk("R2", "first addr", 32'(lg_a[0]), 32'h203);
    chk("R2", "first be", 32'(lg_be[0]), 32'h2);
    chk("R2", "first lane data", 32'(lg_wd[0][15:8]), 32'h34);
    chk("R2", "second addr", 32'(lg_a[1]), 32'h204);
    chk("R2", "second be", 32'(lg_be[1]), 32'h1);
    chk("R2", "second lane data", 32'(lg_wd[1][7:0]), 32'h12);
    run(0, 0, 1, 20'h00203, 16'h0, 0);
    chk("R5", "split read data", 32'(got_data), 32'h1234);
    chk("R2", "split read cycles", 32'(nlog), 32'd2);
  endtask

  task automatic t_r3_bytes;
    bus8 = 1'b0; ws = 0;
    run(0, 1, 0, 20'h00300, 16'h99AB, 0);
    chk("R3", "even byte be", 32'(lg_be[0]), 32'h1);
    chk("R3", "even byte lane", 32'(lg_wd[0][7:0]), 32'hAB);
    run(0, 1, 0, 20'h00301, 16'h99CD, 0);
    chk("R3", "odd byte cycles", 32'(nlog), 32'd1);
    chk("R3", "odd byte be", 32'(lg_be[0]), 32'h2);
    chk("R3", "odd byte lane", 32'(lg_wd[0][15:8]), 32'hCD);
    run(0, 0, 0, 20'h00301, 16'h0, 0);
    chk("R3", "odd byte read", 32'(got_data), 32'h00CD);
    chk("R3", "odd byte count", 32'(got_bytes), 32'd1);
    run(0, 0, 1, 20'h00300, 16'h0, 0);
    chk("R5", "bytes combine as word", 32'(got_data), 32'hCDAB);
  endtask

  task automatic t_r4_narrow_bus;
    bus8 = 1'b1; ws = 0;
    run(0, 0, 1, 20'h00400, 16'h0, 0);
    chk("R4", "even word cycles", 32'(nlog), 32'd2);
    chk("R4", "first addr", 32'(lg_a[0]), 32'h400);
    chk("R4", "second addr", 32'(lg_a[1]), 32'h401);
    chk("R4", "first be", 32'(lg_be[0]), 32'h1);
    chk("R4", "second be", 32'(lg_be[1]), 32'h1);
    chk("R5", "narrow read data", 32'(got_data), 32'({pat(20'h401), pat(20'h400)}));
    run(0, 1, 1, 20'h00500, 16'hA55A, 0);
    chk("R4", "write low byte first", 32'(lg_wd[0][7:0]), 32'h5A);
    chk("R4", "write high byte second", 32'(lg_wd[1][7:0]), 32'hA5);
    bus8 = 1'b0;
    run(0, 0, 1, 20'h00500, 16'h0, 0);
    chk("R5", "cross-width readback", 32'(got_data), 32'hA55A);
  endtask

  task automatic t_r6_wait_states;
    bus8 = 1'b0; ws = 3;
    run(0, 0, 1, 20'h00203, 16'h0, 0);
    chk("R6", "split latency with waits", 32'(got_cyc), 32'd8);
    chk("R6", "bus cycles unchanged", 32'(nlog), 32'd2);
    chk("R6", "data with waits", 32'(got_data), 32'h1234);
    ws = 2;
    run(0, 0, 1, 20'h00100, 16'h0, 0);
    chk("R7", "aligned latency with waits", 32'(got_cyc), 32'd3);
    ws = 0;
  endtask

  task automatic t_r8_wrap;
    bus8 = 1'b0; ws = 0;
    run(0, 0, 1, 20'hFFFFF, 16'h0, 0);
    chk("R8", "first addr", 32'(lg_a[0]), 32'hFFFFF);
    chk("R8", "wrapped addr", 32'(lg_a[1]), 32'h00000);
    chk("R8", "wrapped be", 32'(lg_be[1]), 32'h1);
    chk("R8", "wrapped data", 32'(got_data), 32'({pat(20'h0), pat(20'hFFFFF)}));
    bus8 = 1'b1;
    run(0, 0, 1, 20'hFFFFF, 16'h0, 0);
    chk("R8", "narrow wrapped addr", 32'(lg_a[1]), 32'h00000);
    chk("R8", "narrow wrapped data", 32'(got_data), 32'({pat(20'h0), pat(20'hFFFFF)}));
    bus8 = 1'b0;
  endtask

  task automatic t_r9_wide_fetch;
    bus8 = 1'b0; ws = 0;
    xfer(20'h00601);
    run(1, 1, 1, 20'h12345, 16'hFFFF, 0);
    chk("R9", "odd fetch cycles", 32'(nlog), 32'd1);
    chk("R11", "fetch uses pointer", 32'(lg_a[0]), 32'h601);
    chk("R11", "fetch never writes", 32'(lg_wr[0]), 32'd0);
    chk("R9", "odd fetch be", 32'(lg_be[0]), 32'h2);
    chk("R9", "odd fetch data", 32'(got_data), 32'({8'h00, pat(20'h601)}));
    chk("R9", "odd fetch bytes", 32'(got_bytes), 32'd1);
    chk("R9", "pointer after odd fetch", 32'(fetch_addr), 32'h602);
    run(1, 0, 0, 20'h0, 16'h0, 0);
    chk("R9", "next fetch addr", 32'(lg_a[0]), 32'h602);
    chk("R9", "next fetch be", 32'(lg_be[0]), 32'h3);
    chk("R9", "next fetch data", 32'(got_data), 32'({pat(20'h603), pat(20'h602)}));
    chk("R9", "next fetch bytes", 32'(got_bytes), 32'd2);
    chk("R9", "pointer after word fetch", 32'(fetch_addr), 32'h604);
    xfer(20'h00700);
    run(1, 0, 0, 20'h0, 16'h0, 0);
    chk("R9", "even target fetch be", 32'(lg_be[0]), 32'h3);
    chk("R9", "pointer after even target", 32'(fetch_addr), 32'h702);
    xfer(20'hFFFFF);
    run(1, 0, 0, 20'h0, 16'h0, 0);
    chk("R8", "pointer wraps", 32'(fetch_addr), 32'h00000);
  endtask

  task automatic t_r10_narrow_fetch;
    bus8 = 1'b1; ws = 1;
    xfer(20'h00800);
    run(1, 0, 0, 20'h0, 16'h0, 0);
    chk("R10", "first fetch be", 32'(lg_be[0]), 32'h1);
    chk("R10", "first fetch bytes", 32'(got_bytes), 32'd1);
    chk("R10", "first fetch data", 32'(got_data), 32'({8'h00, pat(20'h800)}));
    run(1, 0, 0, 20'h0, 16'h0, 0);
    chk("R10", "second fetch addr", 32'(lg_a[0]), 32'h801);
    chk("R10", "pointer after two", 32'(fetch_addr), 32'h802);
    bus8 = 1'b0; ws = 0;
  endtask

  task automatic t_r12_busy_ignored;
    bus8 = 1'b0; ws = 2;
    run(0, 0, 1, 20'h00901, 16'h0, 1);
    chk("R12", "no extra bus cycle", 32'(nlog), 32'd2);
    chk("R12", "first addr kept", 32'(lg_a[0]), 32'h901);
    chk("R12", "done still one cycle", 32'(busy), 32'd0);
    ws = 0;
    run(0, 0, 1, 20'h00A00, 16'h0, 0);
    chk("R12", "intruding write absent", 32'(got_data), 32'({pat(20'hA01), pat(20'hA00)}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_r1_aligned_word();
    t_r2_odd_word();
    t_r3_bytes();
    t_r4_narrow_bus();
    t_r6_wait_states();
    t_r8_wrap();
    t_r9_wide_fetch();
    t_r10_narrow_fetch();
    t_r12_busy_ignored();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule